// File: doc/BRIEF.md
# Self-Programming Command Sequencer

This block holds the 8-bit control and status register through which software starts flash self-programming operations. Software arms a command by writing one of five exact bit patterns into the low five bits of the register. The command runs only if a store-instruction strobe follows within a short window. The five commands are: load a word into the temporary page buffer, erase a page, write a page, set the lock bits, and re-enable reads of the read-while-write section. If no strobe arrives in time, the armed bits clear without any action.

For an erase or a write, the enable bit and the command bit stay set until the external flash reports that it has finished. An erase or write that targets the read-while-write region sets a busy flag, and that flag blocks reads of the region. Software clears the flag with the re-enable command once the flash is idle, or by loading a word into the buffer. A ready interrupt is raised while interrupt enable is set and the enable bit is clear. The flash array timing and the CPU are outside this block.

Top module: `selfprog_ctl`

## Requirements
- R1: After reset the register reads 0x00. The read layout, from bit 7 down to bit 0, is: interrupt enable, section busy, a constant 0, re-enable command, lock command, write command, erase command, enable.
- R2: A write arms a command only when its low five bits are 00001 (buffer fill), 00011 (erase), 00101 (write), 01001 (lock set) or 10001 (re-enable). Any other low-bit value is ignored. All low-bit writes are also ignored while an erase or write is running.
- R3: An armed command executes if the strobe is high in any of the four cycles that follow the arming write. If it is not, the low five bits read 0 from the fifth cycle on and a later strobe does nothing.
- R4: A buffer fill produces a one-cycle buffer-write pulse in the cycle after the strobe. The pulse carries the word address (the strobe address shifted right by one, so bit 0 is dropped) and the 16-bit data, and the enable bit clears.
- R5: An erase or write produces a one-cycle start pulse that carries the page number (strobe address bits above PAGE_LSB). The enable bit and the command bit then stay set until the flash-busy input has been seen high and then low, and they read 0 in the next cycle.
- R6: An erase or write whose page number is below RWW_PAGES sets the section-busy bit (bit 6). A buffer fill clears the bit, and so does an executed re-enable command.
- R7: A re-enable strobe while the flash-busy input is high has no effect: there is no pulse and the busy bit stays set. Arming re-enable while the buffer holds words loaded since the last page write gives a one-cycle discard pulse.
- R8: The interrupt output is high exactly while bit 7 is 1 and bit 0 is 0.
- R9: A lock-set strobe produces a one-cycle lock pulse that carries the low data byte. The address and the high data byte are ignored.
- R10: A valid arming write made while a command is already armed restarts the four-cycle window. An invalid write leaves the window running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read value |
| store_i | input | 1 | Store-instruction strobe |
| store_addr_i | input | ADDR_W | Byte address of the store |
| store_data_i | input | DATA_W | Data word of the store |
| flash_busy_i | input | 1 | Flash array is running an erase or write |
| buf_wr_o | output | 1 | Temporary-buffer write pulse |
| buf_waddr_o | output | ADDR_W-1 | Buffer word address |
| buf_wdata_o | output | DATA_W | Buffer write data |
| erase_start_o | output | 1 | Page-erase start pulse |
| write_start_o | output | 1 | Page-write start pulse |
| page_o | output | ADDR_W-PAGE_LSB | Page number for erase or write |
| lock_wr_o | output | 1 | Lock-bit set pulse |
| lock_val_o | output | 8 | New lock value |
| rww_reen_o | output | 1 | Read-while-write section re-enabled pulse |
| buf_discard_o | output | 1 | Buffer contents discarded pulse |
| irq_o | output | 1 | Ready interrupt |

## Verification
A wrong sequencer state shows up in the register read value within a cycle or two. A window counter that is off by one leaves the low bits set one cycle too long, or clears them one cycle early, so the bench reads the register exactly in the fourth and fifth cycles after an arming write. A lost or stale busy or buffer-loaded flag stays hidden until the next fill, re-enable or arming write. At that point it surfaces as a missing or extra pulse, or as a wrong bit 6. The scoreboard flags any pulse that nobody expected, so a command that runs twice or outside its window is caught in the cycle it happens.

// File: rtl/selfprog_pkg.sv
package selfprog_pkg;

   typedef enum logic [2:0] {
      CMD_NONE,
      CMD_FILL,
      CMD_ERASE,
      CMD_WRITE,
      CMD_LOCK,
      CMD_REEN
   } cmd_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ARMED,
      ST_LAUNCH,
      ST_RUN
   } seq_e;

   localparam int REG_W  = 8;
   localparam int LOW_W  = 5;
   localparam int LOCK_W = 8;
   localparam int BIT_IE   = 7;
   localparam int BIT_BUSY = 6;

   localparam logic [LOW_W-1:0] PAT_FILL  = 5'b00001;
   localparam logic [LOW_W-1:0] PAT_ERASE = 5'b00011;
   localparam logic [LOW_W-1:0] PAT_WRITE = 5'b00101;
   localparam logic [LOW_W-1:0] PAT_LOCK  = 5'b01001;
   localparam logic [LOW_W-1:0] PAT_REEN  = 5'b10001;

   function automatic cmd_e pat_decode(logic [LOW_W-1:0] p);
      cmd_e c;
      case (p)
         PAT_FILL:  c = CMD_FILL;
         PAT_ERASE: c = CMD_ERASE;
         PAT_WRITE: c = CMD_WRITE;
         PAT_LOCK:  c = CMD_LOCK;
         PAT_REEN:  c = CMD_REEN;
         default:   c = CMD_NONE;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/selfprog_decode.sv
module selfprog_decode
   import selfprog_pkg::*;
(
   input  logic [LOW_W-1:0] pat_i,
   output cmd_e             cmd_o,
   output logic             valid_o
);
   always_comb begin
      cmd_o   = pat_decode(pat_i);
      valid_o = (cmd_o != CMD_NONE);
   end
endmodule

// File: rtl/selfprog_window.sv
module selfprog_window #(
   parameter int WINDOW = 4,
   parameter int CNT_W  = $clog2(WINDOW + 1)
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic load_i,
   input  logic tick_i,
   output logic expire_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= CNT_W'(WINDOW);
      end else if (tick_i && (cnt_q != '0)) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign expire_o = tick_i && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/selfprog_section.sv
module selfprog_section #(
   parameter int PG_W      = 8,
   parameter int RWW_PAGES = 224
) (
   input  logic [PG_W-1:0] page_i,
   output logic            in_rww_o
);
   localparam longint NPAGES = longint'(1) << PG_W;

   generate
      if (RWW_PAGES <= 0) begin : g_none
         logic unused_page;
         assign unused_page = ^page_i;
         assign in_rww_o = 1'b0;
      end else if (longint'(RWW_PAGES) >= NPAGES) begin : g_all
         logic unused_page;
         assign unused_page = ^page_i;
         assign in_rww_o = 1'b1;
      end else begin : g_cmp
         assign in_rww_o = (page_i < PG_W'(RWW_PAGES));
      end
   endgenerate
endmodule

// File: rtl/selfprog_ctl.sv
module selfprog_ctl
   import selfprog_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 16,
   parameter int PAGE_LSB  = 8,
   parameter int RWW_PAGES = 224,
   parameter int WINDOW    = 4
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       reg_we_i,
   input  logic [7:0]                 reg_wdata_i,
   output logic [7:0]                 reg_rdata_o,
   input  logic                       store_i,
   input  logic [ADDR_W-1:0]          store_addr_i,
   input  logic [DATA_W-1:0]          store_data_i,
   input  logic                       flash_busy_i,
   output logic                       buf_wr_o,
   output logic [ADDR_W-2:0]          buf_waddr_o,
   output logic [DATA_W-1:0]          buf_wdata_o,
   output logic                       erase_start_o,
   output logic                       write_start_o,
   output logic [ADDR_W-PAGE_LSB-1:0] page_o,
   output logic                       lock_wr_o,
   output logic [7:0]                 lock_val_o,
   output logic                       rww_reen_o,
   output logic                       buf_discard_o,
   output logic                       irq_o
);
   localparam int PG_W  = ADDR_W - PAGE_LSB;
   localparam int WA_W  = ADDR_W - 1;
   localparam int CNT_W = $clog2(WINDOW + 1);

   generate
      if (PAGE_LSB < 1 || PAGE_LSB >= ADDR_W) begin : g_bad_page
         $error("selfprog_ctl: PAGE_LSB must lie in 1..ADDR_W-1");
      end
      if (DATA_W < LOCK_W) begin : g_bad_data
         $error("selfprog_ctl: DATA_W must hold the lock byte");
      end
      if (WINDOW < 1) begin : g_bad_win
         $error("selfprog_ctl: WINDOW must be at least one cycle");
      end
   endgenerate

   seq_e                st_q;
   logic                ie_q, busy_q, loaded_q;
   logic [LOW_W-1:0]    low_q;
   logic                buf_wr_q, erase_q, write_q, lock_q, reen_q, discard_q;
   logic [WA_W-1:0]     waddr_q;
   logic [DATA_W-1:0]   wdata_q;
   logic [PG_W-1:0]     page_q;
   logic [LOCK_W-1:0]   lockv_q;

   cmd_e wr_cmd, cur_cmd;
   logic wr_valid, cur_valid;
   logic in_rww, expire;
   logic armed, accept, open_st, wr_ok, tick;
   logic unused_bits;

   assign unused_bits = store_addr_i[0] ^ cur_valid;

   selfprog_decode u_dec_wr (
      .pat_i   (reg_wdata_i[LOW_W-1:0]),
      .cmd_o   (wr_cmd),
      .valid_o (wr_valid)
   );

   selfprog_decode u_dec_cur (
      .pat_i   (low_q),
      .cmd_o   (cur_cmd),
      .valid_o (cur_valid)
   );

   selfprog_section #(.PG_W(PG_W), .RWW_PAGES(RWW_PAGES)) u_sec (
      .page_i   (store_addr_i[ADDR_W-1:PAGE_LSB]),
      .in_rww_o (in_rww)
   );

   assign armed   = (st_q == ST_ARMED);
   assign accept  = armed && store_i;
   assign open_st = (st_q == ST_IDLE) || armed;
   assign wr_ok   = reg_we_i && wr_valid && open_st && !accept;
   assign tick    = armed && !store_i && !wr_ok;

   selfprog_window #(.WINDOW(WINDOW), .CNT_W(CNT_W)) u_win (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (wr_ok),
      .tick_i   (tick),
      .expire_o (expire)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q      <= ST_IDLE;
         ie_q      <= 1'b0;
         busy_q    <= 1'b0;
         loaded_q  <= 1'b0;
         low_q     <= '0;
         buf_wr_q  <= 1'b0;
         erase_q   <= 1'b0;
         write_q   <= 1'b0;
         lock_q    <= 1'b0;
         reen_q    <= 1'b0;
         discard_q <= 1'b0;
         waddr_q   <= '0;
         wdata_q   <= '0;
         page_q    <= '0;
         lockv_q   <= '0;
      end else begin
         buf_wr_q  <= 1'b0;
         erase_q   <= 1'b0;
         write_q   <= 1'b0;
         lock_q    <= 1'b0;
         reen_q    <= 1'b0;
         discard_q <= 1'b0;
         if (reg_we_i) begin
            ie_q <= reg_wdata_i[BIT_IE];
         end
         case (st_q)
            ST_IDLE, ST_ARMED: begin
               if (accept) begin
                  case (cur_cmd)
                     CMD_FILL: begin
                        buf_wr_q <= 1'b1;
                        waddr_q  <= store_addr_i[ADDR_W-1:1];
                        wdata_q  <= store_data_i;
                        busy_q   <= 1'b0;
                        loaded_q <= 1'b1;
                        low_q    <= '0;
                        st_q     <= ST_IDLE;
                     end
                     CMD_ERASE, CMD_WRITE: begin
                        erase_q <= (cur_cmd == CMD_ERASE);
                        write_q <= (cur_cmd == CMD_WRITE);
                        page_q  <= store_addr_i[ADDR_W-1:PAGE_LSB];
                        if (in_rww) begin
                           busy_q <= 1'b1;
                        end
                        if (cur_cmd == CMD_WRITE) begin
                           loaded_q <= 1'b0;
                        end
                        st_q <= ST_LAUNCH;
                     end
                     CMD_LOCK: begin
                        lock_q  <= 1'b1;
                        lockv_q <= store_data_i[LOCK_W-1:0];
                        low_q   <= '0;
                        st_q    <= ST_IDLE;
                     end
                     CMD_REEN: begin
                        if (!flash_busy_i) begin
                           busy_q <= 1'b0;
                           reen_q <= 1'b1;
                        end
                        low_q <= '0;
                        st_q  <= ST_IDLE;
                     end
                     default: begin
                        low_q <= '0;
                        st_q  <= ST_IDLE;
                     end
                  endcase
               end else if (wr_ok) begin
                  low_q <= reg_wdata_i[LOW_W-1:0];
                  st_q  <= ST_ARMED;
                  if ((wr_cmd == CMD_REEN) && loaded_q) begin
                     discard_q <= 1'b1;
                     loaded_q  <= 1'b0;
                  end
               end else if (expire) begin
                  low_q <= '0;
                  st_q  <= ST_IDLE;
               end
            end
            ST_LAUNCH: begin
               if (flash_busy_i) begin
                  st_q <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (!flash_busy_i) begin
                  low_q <= '0;
                  st_q  <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign reg_rdata_o   = {ie_q, busy_q, 1'b0, low_q};
   assign irq_o         = ie_q && !low_q[0];
   assign buf_wr_o      = buf_wr_q;
   assign buf_waddr_o   = waddr_q;
   assign buf_wdata_o   = wdata_q;
   assign erase_start_o = erase_q;
   assign write_start_o = write_q;
   assign page_o        = page_q;
   assign lock_wr_o     = lock_q;
   assign lock_val_o    = lockv_q;
   assign rww_reen_o    = reen_q;
   assign buf_discard_o = discard_q;
endmodule

// File: rtl/selfprog_ctl_chk.sv
module selfprog_ctl_chk
   import selfprog_pkg::*;
(
   input logic       clk_i,
   input logic       rst_ni,
   input logic       reg_we_i,
   input logic [7:0] reg_wdata_i,
   input logic [7:0] reg_rdata_o,
   input logic       flash_busy_i,
   input logic       buf_wr_o,
   input logic       erase_start_o,
   input logic       write_start_o,
   input logic       lock_wr_o,
   input logic       rww_reen_o,
   input logic       irq_o
);
   p_zero_bit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      reg_rdata_o[5] == 1'b0);

   p_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o == (reg_rdata_o[7] && !reg_rdata_o[0]));

   p_one_cmd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({buf_wr_o, erase_start_o, write_start_o, lock_wr_o, rww_reen_o}));

   p_bad_pattern_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_we_i && (pat_decode(reg_wdata_i[4:0]) == CMD_NONE) && (reg_rdata_o[4:0] == 5'd0))
      |=> (reg_rdata_o[4:0] == 5'd0));

   p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (erase_start_o || write_start_o) |-> reg_rdata_o[0]);

   p_reen_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rww_reen_o |-> (!$past(flash_busy_i) && !reg_rdata_o[6]));

   p_fill_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      buf_wr_o |-> (!reg_rdata_o[6] && !reg_rdata_o[0]));
endmodule

bind selfprog_ctl selfprog_ctl_chk u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .reg_we_i      (reg_we_i),
   .reg_wdata_i   (reg_wdata_i),
   .reg_rdata_o   (reg_rdata_o),
   .flash_busy_i  (flash_busy_i),
   .buf_wr_o      (buf_wr_o),
   .erase_start_o (erase_start_o),
   .write_start_o (write_start_o),
   .lock_wr_o     (lock_wr_o),
   .rww_reen_o    (rww_reen_o),
   .irq_o         (irq_o)
);

// File: tb/selfprog_ctl_tb.sv
`timescale 1ns/1ps
module selfprog_ctl_tb_top;
   localparam int EV_BUF = 0, EV_ERASE = 1, EV_WRITE = 2, EV_LOCK = 3, EV_REEN = 4, EV_DISC = 5;

   typedef struct {
      int          kind;
      logic [31:0] a;
      logic [31:0] d;
      string       req;
   } ev_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        store = 1'b0;
   logic [15:0] store_addr = '0;
   logic [15:0] store_data = '0;
   logic        flash_busy = 1'b0;
   logic        buf_wr, erase_st, write_st, lock_wr, reen, discard, irq;
   logic [14:0] buf_waddr;
   logic [15:0] buf_wdata;
   logic [7:0]  page, lock_val;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   ev_t expq[$];

   always #4 clk = ~clk;

   selfprog_ctl dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .reg_we_i(reg_we), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
      .store_i(store), .store_addr_i(store_addr), .store_data_i(store_data),
      .flash_busy_i(flash_busy),
      .buf_wr_o(buf_wr), .buf_waddr_o(buf_waddr), .buf_wdata_o(buf_wdata),
      .erase_start_o(erase_st), .write_start_o(write_st), .page_o(page),
      .lock_wr_o(lock_wr), .lock_val_o(lock_val),
      .rww_reen_o(reen), .buf_discard_o(discard), .irq_o(irq)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic expect_ev(int kind, logic [31:0] a, logic [31:0] d, string req);
      ev_t e;
      e.kind = kind; e.a = a; e.d = d; e.req = req;
      expq.push_back(e);
   endtask

   task automatic wr(logic [7:0] v);
      @(negedge clk);
      reg_we = 1'b1; reg_wdata = v;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic do_store(logic [15:0] a, logic [15:0] d);
      store = 1'b1; store_addr = a; store_data = d;
      @(negedge clk);
      store = 1'b0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic observe(int kind, logic [31:0] a, logic [31:0] d);
      ev_t e;
      checks++;
      if (expq.size() == 0) begin
         errors++;
         $display("FAIL unexpected pulse kind=%0d actual=0x%0h/0x%0h expected=none", kind, a, d);
      end else begin
         e = expq.pop_front();
         if (e.kind != kind || e.a !== a || e.d !== d) begin
            errors++;
            $display("FAIL %s actual=%0d/0x%0h/0x%0h expected=%0d/0x%0h/0x%0h",
                     e.req, kind, a, d, e.kind, e.a, e.d);
         end
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (buf_wr)   observe(EV_BUF, 32'(buf_waddr), 32'(buf_wdata));
         if (erase_st) observe(EV_ERASE, 32'(page), 32'd0);
         if (write_st) observe(EV_WRITE, 32'(page), 32'd0);
         if (lock_wr)  observe(EV_LOCK, 32'd0, 32'(lock_val));
         if (reen)     observe(EV_REEN, 32'd0, 32'd0);
         if (discard)  observe(EV_DISC, 32'd0, 32'd0);
      end
   end

   task automatic finish_run();
      done = 1'b1;
      while (expq.size() > 0) begin
         ev_t e;
         e = expq.pop_front();
         checks++; errors++;
         $display("FAIL %s actual=missing expected=kind %0d", e.req, e.kind);
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset value", 32'(reg_rdata), 32'h00);
      chk("R8 irq after reset", 32'(irq), 32'd0);

      // R4: buffer fill, bit 0 of the address dropped
      wr(8'h01);
      chk("R2 fill armed", 32'(reg_rdata), 32'h01);
      expect_ev(EV_BUF, 32'h0091, 32'hBEEF, "R4 fill");
      do_store(16'h0123, 16'hBEEF);
      chk("R4 enable cleared", 32'(reg_rdata), 32'h00);

      // R3: strobe in the fourth cycle is accepted
      wr(8'h01);
      idle(3);
      expect_ev(EV_BUF, 32'h0010, 32'h1111, "R3 last window cycle");
      do_store(16'h0020, 16'h1111);
      // R3: no strobe for four cycles -> expired
      wr(8'h01);
      idle(3);
      chk("R3 still armed in cycle 4", 32'(reg_rdata), 32'h01);
      idle(1);
      chk("R3 expired in cycle 5", 32'(reg_rdata), 32'h00);
      do_store(16'h0040, 16'h2222);
      idle(2);

      // R2: invalid patterns ignored
      wr(8'h07);
      chk("R2 pattern 00111 ignored", 32'(reg_rdata), 32'h00);
      wr(8'h10);
      chk("R2 pattern 10000 ignored", 32'(reg_rdata), 32'h00);
      do_store(16'h0060, 16'h3333);
      idle(2);

      // R9: lock set takes only the low data byte
      wr(8'h09);
      chk("R2 lock armed", 32'(reg_rdata), 32'h09);
      expect_ev(EV_LOCK, 32'd0, 32'h5A, "R9 lock value");
      do_store(16'hFFFF, 16'hA55A);
      chk("R9 cleared", 32'(reg_rdata), 32'h00);

      // R10: valid rewrite reloads the window
      wr(8'h01);
      idle(3);
      wr(8'h01);
      idle(3);
      chk("R10 reloaded window still armed", 32'(reg_rdata), 32'h01);
      expect_ev(EV_BUF, 32'h0200, 32'h4444, "R10 accepted after reload");
      do_store(16'h0400, 16'h4444);
      // R10: invalid write does not reload
      wr(8'h01);
      idle(2);
      wr(8'h07);
      idle(1);
      chk("R10 invalid write kept countdown", 32'(reg_rdata), 32'h00);

      // R5/R6: erase on read-while-write page
      wr(8'h03);
      expect_ev(EV_ERASE, 32'h12, 32'd0, "R5 erase page");
      do_store(16'h1234, 16'hFFFF);
      chk("R6 busy set by erase", 32'(reg_rdata), 32'h43);
      flash_busy = 1'b1;
      idle(2);
      wr(8'h01);
      chk("R2 write ignored during erase", 32'(reg_rdata), 32'h43);
      idle(3);
      chk("R5 enable held during erase", 32'(reg_rdata), 32'h43);
      flash_busy = 1'b0;
      @(negedge clk);
      chk("R5 cleared after done", 32'(reg_rdata), 32'h40);

      // R7: re-enable while flash busy does nothing (discard since buffer loaded)
      expect_ev(EV_DISC, 32'd0, 32'd0, "R7 discard on arming");
      wr(8'h11);
      flash_busy = 1'b1;
      do_store(16'h0000, 16'h0000);
      flash_busy = 1'b0;
      chk("R7 busy kept when flash busy", 32'(reg_rdata), 32'h40);
      idle(1);

      // R6/R7: re-enable with flash idle
      wr(8'h11);
      expect_ev(EV_REEN, 32'd0, 32'd0, "R7 re-enable");
      do_store(16'h0000, 16'h0000);
      chk("R6 busy cleared by re-enable", 32'(reg_rdata), 32'h00);

      // R5/R6: write on page outside section
      wr(8'h05);
      expect_ev(EV_WRITE, 32'hF0, 32'd0, "R5 write page");
      do_store(16'hF000, 16'h0000);
      chk("R6 no busy outside section", 32'(reg_rdata), 32'h05);
      flash_busy = 1'b1;
      idle(3);
      flash_busy = 1'b0;
      @(negedge clk);
      chk("R5 write cleared", 32'(reg_rdata), 32'h00);

      // R6: fill clears busy
      wr(8'h03);
      expect_ev(EV_ERASE, 32'h00, 32'd0, "R5 erase page 0");
      do_store(16'h0010, 16'h0000);
      flash_busy = 1'b1;
      idle(2);
      flash_busy = 1'b0;
      @(negedge clk);
      chk("R6 busy after erase", 32'(reg_rdata), 32'h40);
      wr(8'h01);
      expect_ev(EV_BUF, 32'h0003, 32'h7777, "R6 fill");
      do_store(16'h0006, 16'h7777);
      chk("R6 busy cleared by fill", 32'(reg_rdata), 32'h00);

      // R7: arming re-enable with loaded buffer discards
      expect_ev(EV_DISC, 32'd0, 32'd0, "R7 discard");
      wr(8'h11);
      expect_ev(EV_REEN, 32'd0, 32'd0, "R7 re-enable after discard");
      do_store(16'h0000, 16'h0000);
      chk("R7 idle after re-enable", 32'(reg_rdata), 32'h00);

      // R8: interrupt
      wr(8'h80);
      chk("R8 ie alone", 32'(reg_rdata), 32'h80);
      chk("R8 irq high", 32'(irq), 32'd1);
      wr(8'h81);
      chk("R8 irq low while armed", 32'(irq), 32'd0);
      idle(4);
      chk("R8 irq back after expiry", 32'(irq), 32'd1);
      chk("R1 final register", 32'(reg_rdata), 32'h80);

      idle(3);
      finish_run();
   end
endmodule